// File: doc/BRIEF.md
# ATA PIO Bus Access Sequencer

This block sits between a simple host register port and a parallel ATA device bus running in programmed I/O. The host issues a single-cycle read or write strobe with a byte address and, for writes, data. The block turns that into one complete device bus cycle. The top address bits pick the command block or the control block, which sets the two active-low chip selects. The register index is taken from host address bits one position up, so that every 8-bit register sits on an even host address and its data travels on the low byte lane. The read or write strobe is then shaped with setup, pulse and recovery times that are counted in clock cycles.

The timing comes from a per-mode table covering transfer modes 0 to 4. Each nanosecond figure is converted to clock cycles by rounding up at elaboration, so no minimum is ever shortened. A fixed ring-settling margin is added to the setup and total cycle figures but not to the pulse. In the two fastest modes the device can stretch the strobe by pulling its ready line low. After reset the block holds the device reset output low for 30 us and then waits a further 10 us before it accepts any access. The host sees a ready level and a one-cycle completion pulse.

Top module: `ata_pio_seq`

## Requirements
- R1: While `rst_n` is low, both chip selects, both strobes and `dev_rst_n_o` are inactive or low as follows: chip selects and strobes high, `dd_oe_o` low, `host_rdy_o` low, `dev_rst_n_o` low, `mode_o` 0. After release, `dev_rst_n_o` stays low for ceil(30000 ns / Tclk) cycles, counting the release cycle. It then stays high for ceil(10000 ns / Tclk) cycles with `host_rdy_o` low, and then `host_rdy_o` rises.
- R2: An accepted access whose address bits [23:21] are 3'b110 drives `cs0_n_o`=0 and `cs1_n_o`=1. Bits 3'b111 drive `cs0_n_o`=1 and `cs1_n_o`=0. Address bits [20:4] and [0] are ignored. Any other value of bits [23:21] produces no bus cycle: both chip selects stay high and `host_done_o` pulses in the cycle after acceptance.
- R3: `da_o` equals host address bits [3:1] for the whole of the chip-select-active window.
- R4: With S = ceil((setup_ns+100)/Tclk), P = ceil(pulse_ns/Tclk) and C = max(ceil((cycle_ns+100)/Tclk), S+P+1), the chip select is active for C cycles. The strobe goes low S cycles after the chip select asserts and stays low for P cycles. Setup is 100/60/40/40/35 ns, pulse is 400/300/290/80/70 ns and cycle is 600/390/350/190/135 ns for modes 0/1/2/3/4. Reads and writes use the same figures.
- R5: `host_rdy_o` is high only when no access is in progress. `host_done_o` is high for one cycle, namely the first cycle after the chip select deasserts. Host strobes that arrive while `host_rdy_o` is low are ignored.
- R6: A write pulses only `diow_n_o`, and a read pulses only `dior_n_o`. `dd_oe_o` is high for the whole chip-select window of a write and low at all other times. While `dd_oe_o` is high, `dd_o` holds the write data: all 16 bits when `host_wide_i` is 1, or {8'h00, data[7:0]} when it is 0.
- R7: Read data is captured from `dd_i` at the clock edge where `dior_n_o` rises: all 16 bits when wide, or {8'h00, dd_i[7:0]} when narrow. `host_rdata_o` holds that value until the next read is captured, and writes leave it untouched.
- R8: In modes 3 and 4, each clock edge during the strobe at which `iordy_i` is low lengthens the strobe by one cycle. In modes 0 to 2, `iordy_i` has no effect.
- R9: A `mode_set_i` pulse with `mode_i` at most 4 loads `mode_o` at the next edge. A pulse with a value above 4 leaves `mode_o` unchanged. An access runs with the mode that was in force when it was accepted, even if the mode changes during the access.
- R10: If `host_rd_i` and `host_wr_i` are both high at acceptance, the access is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Requested transfer mode |
| mode_set_i | input | 1 | Load `mode_i` as the current mode |
| mode_o | output | 3 | Current mode |
| host_addr_i | input | 24 | Host byte address |
| host_wdata_i | input | 16 | Host write data |
| host_wide_i | input | 1 | 1: 16-bit transfer, 0: 8-bit on low lane |
| host_rd_i | input | 1 | Read request, sampled while ready |
| host_wr_i | input | 1 | Write request, sampled while ready |
| host_rdy_o | output | 1 | Idle and able to accept |
| host_done_o | output | 1 | One-cycle completion pulse |
| host_rdata_o | output | 16 | Last captured read data |
| cs0_n_o | output | 1 | Command block select, active low |
| cs1_n_o | output | 1 | Control block select, active low |
| da_o | output | 3 | Device register index |
| dior_n_o | output | 1 | Read strobe, active low |
| diow_n_o | output | 1 | Write strobe, active low |
| dd_o | output | 16 | Device data out |
| dd_oe_o | output | 1 | Device data output enable |
| dd_i | input | 16 | Device data in |
| iordy_i | input | 1 | Device ready, low requests wait |
| dev_rst_n_o | output | 1 | Device hard reset, active low |

## Verification
A host strobe presented at one negative edge is accepted at the next rising edge. From the sample that follows, the chip select is already active, so the bench counts chip-select, setup and strobe cycles from that sample and expects `host_done_o` at the first sample in which the chip select is inactive; for an address outside the windows that is the very first sample. Read data and `mode_o` change at the same edge that ends the strobe or takes the mode pulse, so the bench reads them at the completion sample or one negative edge later. The reset pulse and the settling wait are counted sample by sample from the negative edge at which reset is released.

// File: rtl/ata_pio_seq.sv
module ata_pio_seq #(
  parameter int unsigned CLK_PS      = 5000,
  parameter int unsigned AW          = 24,
  parameter int unsigned DW          = 16,
  parameter int unsigned CW          = 16,
  parameter int unsigned RING_NS     = 100,
  parameter int unsigned RST_LOW_NS  = 30000,
  parameter int unsigned RST_WAIT_NS = 10000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_i,
  input  logic          mode_set_i,
  output logic [2:0]    mode_o,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic          host_wide_i,
  input  logic          host_rd_i,
  input  logic          host_wr_i,
  output logic          host_rdy_o,
  output logic          host_done_o,
  output logic [DW-1:0] host_rdata_o,
  output logic          cs0_n_o,
  output logic          cs1_n_o,
  output logic [2:0]    da_o,
  output logic          dior_n_o,
  output logic          diow_n_o,
  output logic [DW-1:0] dd_o,
  output logic          dd_oe_o,
  input  logic [DW-1:0] dd_i,
  input  logic          iordy_i,
  output logic          dev_rst_n_o
);

  localparam int unsigned LANE = DW / 2;
  localparam logic [2:0] MAX_MODE   = 3'd4;
  localparam logic [2:0] WAIT_MODE  = 3'd3;
  localparam logic [2:0] WIN_CMD    = 3'b110;
  localparam logic [2:0] WIN_CTL    = 3'b111;

  function automatic int unsigned to_cyc(int unsigned ns);
    return (ns * 1000 + CLK_PS - 1) / CLK_PS;
  endfunction

  function automatic int unsigned tot_ns(int m);
    case (m)
      0: return 600;
      1: return 390;
      2: return 350;
      3: return 190;
      default: return 135;
    endcase
  endfunction

  function automatic int unsigned lead_ns(int m);
    case (m)
      0: return 100;
      1: return 60;
      2: return 40;
      3: return 40;
      default: return 35;
    endcase
  endfunction

  function automatic int unsigned strobe_ns(int m);
    case (m)
      0: return 400;
      1: return 300;
      2: return 290;
      3: return 80;
      default: return 70;
    endcase
  endfunction

  function automatic int unsigned lead_cyc(int m);
    return to_cyc(lead_ns(m) + RING_NS);
  endfunction

  function automatic int unsigned strobe_cyc(int m);
    return to_cyc(strobe_ns(m));
  endfunction

  function automatic int unsigned tail_cyc(int m);
    int unsigned c, used;
    c    = to_cyc(tot_ns(m) + RING_NS);
    used = lead_cyc(m) + strobe_cyc(m);
    return (c > used) ? c - used : 1;
  endfunction

  localparam int unsigned RST_CYC  = to_cyc(RST_LOW_NS);
  localparam int unsigned WAIT_CYC = to_cyc(RST_WAIT_NS);

  typedef enum logic [2:0] {
    S_RST, S_WAIT, S_IDLE, S_LEAD, S_STROBE, S_TAIL
  } st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [2:0]     mode_q, acc_mode;
  logic           acc_wr, acc_wide, acc_ctl, done_q;
  logic [2:0]     acc_da;
  logic [DW-1:0]  acc_wd, rdata_q;

  logic [CW-1:0]  lead_tab   [8];
  logic [CW-1:0]  strobe_tab [8];
  logic [CW-1:0]  tail_tab   [8];

  for (genvar g = 0; g < 8; g++) begin : g_tab
    assign lead_tab[g]   = CW'(lead_cyc(g));
    assign strobe_tab[g] = CW'(strobe_cyc(g));
    assign tail_tab[g]   = CW'(tail_cyc(g));
  end

  wire [2:0] win      = host_addr_i[AW-1:AW-3];
  wire       hit_cmd  = (win == WIN_CMD);
  wire       hit_ctl  = (win == WIN_CTL);
  wire       take     = (st == S_IDLE) && (host_rd_i || host_wr_i);
  wire       busy     = (st == S_LEAD) || (st == S_STROBE) || (st == S_TAIL);
  wire       held     = (acc_mode >= WAIT_MODE) && !iordy_i;
  wire       cnt_zero = (cnt == '0);
  wire [DW-1:0] wd_lane = host_wide_i ? host_wdata_i
                                      : {{LANE{1'b0}}, host_wdata_i[LANE-1:0]};
  wire [DW-1:0] rd_lane = acc_wide ? dd_i : {{LANE{1'b0}}, dd_i[LANE-1:0]};

  logic addr_unused;
  assign addr_unused = ^{host_addr_i[AW-4:4], host_addr_i[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_RST;
      cnt      <= CW'(RST_CYC - 1);
      mode_q   <= '0;
      acc_mode <= '0;
      acc_wr   <= 1'b0;
      acc_wide <= 1'b0;
      acc_ctl  <= 1'b0;
      acc_da   <= '0;
      acc_wd   <= '0;
      rdata_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (mode_set_i && (mode_i <= MAX_MODE))
        mode_q <= mode_i;
      case (st)
        S_RST: begin
          if (cnt_zero) begin
            st  <= S_WAIT;
            cnt <= CW'(WAIT_CYC - 1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        S_WAIT: begin
          if (cnt_zero) st <= S_IDLE;
          else          cnt <= cnt - CW'(1);
        end
        S_IDLE: begin
          if (take) begin
            if (hit_cmd || hit_ctl) begin
              st       <= S_LEAD;
              cnt      <= lead_tab[mode_q] - CW'(1);
              acc_mode <= mode_q;
              acc_wr   <= host_wr_i;
              acc_wide <= host_wide_i;
              acc_ctl  <= hit_ctl;
              acc_da   <= host_addr_i[3:1];
              acc_wd   <= wd_lane;
            end else begin
              done_q <= 1'b1;
            end
          end
        end
        S_LEAD: begin
          if (cnt_zero) begin
            st  <= S_STROBE;
            cnt <= strobe_tab[acc_mode] - CW'(1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        S_STROBE: begin
          if (!held) begin
            if (cnt_zero) begin
              st  <= S_TAIL;
              cnt <= tail_tab[acc_mode] - CW'(1);
              if (!acc_wr) rdata_q <= rd_lane;
            end else begin
              cnt <= cnt - CW'(1);
            end
          end
        end
        S_TAIL: begin
          if (cnt_zero) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mode_o       = mode_q;
  assign host_rdy_o   = (st == S_IDLE);
  assign host_done_o  = done_q;
  assign host_rdata_o = rdata_q;
  assign cs0_n_o      = !(busy && !acc_ctl);
  assign cs1_n_o      = !(busy && acc_ctl);
  assign da_o         = busy ? acc_da : '0;
  assign dior_n_o     = !((st == S_STROBE) && !acc_wr);
  assign diow_n_o     = !((st == S_STROBE) && acc_wr);
  assign dd_oe_o      = busy && acc_wr;
  assign dd_o         = dd_oe_o ? acc_wd : '0;
  assign dev_rst_n_o  = (st != S_RST);

endmodule

// File: rtl/ata_pio_seq_chk.sv
module ata_pio_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  mode_i,
  input logic        mode_set_i,
  input logic [2:0]  mode_o,
  input logic        host_rdy_o,
  input logic        host_done_o,
  input logic [15:0] host_rdata_o,
  input logic        cs0_n_o,
  input logic        cs1_n_o,
  input logic [2:0]  da_o,
  input logic        dior_n_o,
  input logic        diow_n_o,
  input logic        dd_oe_o,
  input logic        dev_rst_n_o
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rst_n_o |-> (cs0_n_o && cs1_n_o && !host_rdy_o));

  p_one_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs0_n_o && !cs1_n_o));

  p_index_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs0_n_o && $past(!cs0_n_o)) |-> $stable(da_o));

  p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dior_n_o || !diow_n_o) |-> (!cs0_n_o || !cs1_n_o));

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_done_o |-> (host_rdy_o && cs0_n_o && cs1_n_o));

  p_rdy_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdy_o |-> (dior_n_o && diow_n_o));

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n_o && !diow_n_o));

  p_drive_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !diow_n_o |-> dd_oe_o);

  p_float_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dd_oe_o |-> dior_n_o);

  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(dior_n_o) |-> $stable(host_rdata_o));

  p_mode_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_set_i && (mode_i > 3'd4)) |=> $stable(mode_o));

  p_mode_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o <= 3'd4);

endmodule

bind ata_pio_seq ata_pio_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .mode_set_i   (mode_set_i),
  .mode_o       (mode_o),
  .host_rdy_o   (host_rdy_o),
  .host_done_o  (host_done_o),
  .host_rdata_o (host_rdata_o),
  .cs0_n_o      (cs0_n_o),
  .cs1_n_o      (cs1_n_o),
  .da_o         (da_o),
  .dior_n_o     (dior_n_o),
  .diow_n_o     (diow_n_o),
  .dd_oe_o      (dd_oe_o),
  .dev_rst_n_o  (dev_rst_n_o)
);

// File: tb/ata_pio_seq_tb.sv
module ata_pio_seq_tb;

  localparam int TCLK_PS = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_i = '0;
  logic        mode_set_i = 1'b0;
  logic [2:0]  mode_o;
  logic [23:0] host_addr_i = '0;
  logic [15:0] host_wdata_i = '0;
  logic        host_wide_i = 1'b0;
  logic        host_rd_i = 1'b0;
  logic        host_wr_i = 1'b0;
  logic        host_rdy_o, host_done_o;
  logic [15:0] host_rdata_o;
  logic        cs0_n_o, cs1_n_o, dior_n_o, diow_n_o, dd_oe_o, dev_rst_n_o;
  logic [2:0]  da_o;
  logic [15:0] dd_o;
  logic [15:0] dd_i = '0;
  logic        iordy_i = 1'b1;

  always #2.5ns clk = ~clk;

  ata_pio_seq #(.CLK_PS(TCLK_PS)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mode_set_i(mode_set_i),
    .mode_o(mode_o), .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
    .host_wide_i(host_wide_i), .host_rd_i(host_rd_i), .host_wr_i(host_wr_i),
    .host_rdy_o(host_rdy_o), .host_done_o(host_done_o),
    .host_rdata_o(host_rdata_o), .cs0_n_o(cs0_n_o), .cs1_n_o(cs1_n_o),
    .da_o(da_o), .dior_n_o(dior_n_o), .diow_n_o(diow_n_o), .dd_o(dd_o),
    .dd_oe_o(dd_oe_o), .dd_i(dd_i), .iordy_i(iordy_i),
    .dev_rst_n_o(dev_rst_n_o)
  );

  int tests = 0;
  int fails = 0;
  bit over  = 0;

  function automatic int cyc(int ns);
    return (ns * 1000 + TCLK_PS - 1) / TCLK_PS;
  endfunction

  function automatic int want_su(int m);
    int t[5] = '{100, 60, 40, 40, 35};
    return cyc(t[m] + 100);
  endfunction

  function automatic int want_pw(int m);
    int t[5] = '{400, 300, 290, 80, 70};
    return cyc(t[m]);
  endfunction

  function automatic int want_cs(int m);
    int t[5] = '{600, 390, 350, 190, 135};
    int c;
    c = cyc(t[m] + 100);
    return (c > want_su(m) + want_pw(m)) ? c : want_su(m) + want_pw(m) + 1;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  mode;
    logic [23:0] addr;
    logic        wr;
    logic        wide;
    logic [15:0] wd;
    logic [15:0] din;
    logic [1:0]  sel;
    logic [2:0]  idx;
    logic [15:0] bus;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 24'hC0000E, 1'b1, 1'b0, 16'hABEC, 16'h0000, 2'b01, 3'd7, 16'h00EC},
    '{3'd0, 24'hC00004, 1'b0, 1'b0, 16'h0000, 16'h5A3C, 2'b01, 3'd2, 16'h003C},
    '{3'd1, 24'hE0000C, 1'b1, 1'b0, 16'h0004, 16'h0000, 2'b10, 3'd6, 16'h0004},
    '{3'd2, 24'hE0000C, 1'b0, 1'b0, 16'h0000, 16'hFF50, 2'b10, 3'd6, 16'h0050},
    '{3'd3, 24'hC00000, 1'b1, 1'b1, 16'hBEEF, 16'h0000, 2'b01, 3'd0, 16'hBEEF},
    '{3'd4, 24'hC00000, 1'b0, 1'b1, 16'h0000, 16'h1234, 2'b01, 3'd0, 16'h1234},
    '{3'd4, 24'hD5FFF2, 1'b0, 1'b0, 16'h0000, 16'h80C1, 2'b01, 3'd1, 16'h00C1},
    '{3'd3, 24'hFFFFFA, 1'b1, 1'b0, 16'h1177, 16'h0000, 2'b10, 3'd5, 16'h0077}
  };

  int          r_cs, r_su, r_pw, r_gap, r_oe_bad, r_wrong, r_bus_var;
  logic [1:0]  r_sel;
  logic [2:0]  r_idx;
  logic [15:0] r_bus, r_rdata;
  bit          r_done, r_done_ok;

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    mode_i = m;
    mode_set_i = 1'b1;
    @(negedge clk);
    mode_set_i = 1'b0;
  endtask

  task automatic run_acc(input logic [23:0] a, input logic w, input logic r,
                         input logic wide, input logic [15:0] wd,
                         input int lo_n, input bit poke);
    bit seen, poked, poke_used, wr_eff, cs_act, prev_cs;
    int lo_left;
    r_cs = 0; r_su = 0; r_pw = 0; r_gap = 0; r_oe_bad = 0; r_wrong = 0;
    r_bus_var = 0; r_sel = 2'b11; r_idx = '0; r_bus = '0; r_rdata = '0;
    r_done = 0; r_done_ok = 0;
    seen = 0; poked = 0; poke_used = 0; prev_cs = 0; lo_left = 0;
    wr_eff = w;
    @(negedge clk);
    host_addr_i = a; host_wdata_i = wd; host_wide_i = wide;
    host_wr_i = w; host_rd_i = r;
    @(negedge clk);
    host_wr_i = 1'b0; host_rd_i = 1'b0;
    for (int it = 0; it < 3000; it++) begin
      if (poked) begin
        mode_set_i = 1'b0; host_rd_i = 1'b0; poked = 0;
      end
      cs_act = !cs0_n_o || !cs1_n_o;
      if (host_done_o) begin
        r_done = 1;
        r_done_ok = !cs_act && ((r_cs == 0) || prev_cs);
        r_rdata = host_rdata_o;
        break;
      end
      if (cs_act) begin
        r_cs++;
        if (r_cs == 1) begin
          r_sel = {cs0_n_o, cs1_n_o};
          r_idx = da_o;
        end
        if (da_o != r_idx) r_gap++;
        if (dd_oe_o != wr_eff) r_oe_bad++;
        if (wr_eff ? !dior_n_o : !diow_n_o) r_wrong++;
        if (wr_eff ? !diow_n_o : !dior_n_o) begin
          r_pw++;
          if (!seen) begin
            seen = 1;
            r_bus = dd_o;
            if (lo_n > 0) begin
              iordy_i = 1'b0;
              lo_left = lo_n;
            end
          end else if (dd_o != r_bus) begin
            r_bus_var++;
          end
        end else if (!seen) begin
          r_su++;
        end
      end else if (r_cs > 0) begin
        r_gap++;
      end
      if (poke && !poke_used && r_cs == 3) begin
        mode_i = 3'd4; mode_set_i = 1'b1; host_rd_i = 1'b1;
        poked = 1; poke_used = 1;
      end
      prev_cs = cs_act;
      @(negedge clk);
      if (lo_left > 0) begin
        lo_left--;
        if (lo_left == 0) iordy_i = 1'b1;
      end
    end
    iordy_i = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!over) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    int n;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "cs0_n in reset", cs0_n_o, 1);
    chk("R1", "cs1_n in reset", cs1_n_o, 1);
    chk("R1", "strobes in reset", {dior_n_o, diow_n_o}, 2'b11);
    chk("R1", "oe in reset", dd_oe_o, 0);
    chk("R1", "rdy in reset", host_rdy_o, 0);
    chk("R1", "dev reset in reset", dev_rst_n_o, 0);
    chk("R1", "mode in reset", mode_o, 0);

    rst_n = 1'b1;
    n = 0;
    while (!dev_rst_n_o && n < 20000) begin
      n++;
      @(negedge clk);
    end
    chk("R1", "device reset low cycles", n, cyc(30000));
    n = 0;
    while (!host_rdy_o && n < 20000) begin
      n++;
      @(negedge clk);
    end
    chk("R1", "settling cycles", n, cyc(10000));

    for (int v = 0; v < NV; v++) begin
      set_mode(VEC[v].mode);
      dd_i = VEC[v].din;
      run_acc(VEC[v].addr, VEC[v].wr, !VEC[v].wr, VEC[v].wide, VEC[v].wd, 0, 0);
      chk("R2", $sformatf("vec%0d select", v), r_sel, VEC[v].sel);
      chk("R3", $sformatf("vec%0d index", v), r_idx, VEC[v].idx);
      chk("R4", $sformatf("vec%0d setup", v), r_su, want_su(VEC[v].mode));
      chk("R4", $sformatf("vec%0d pulse", v), r_pw, want_pw(VEC[v].mode));
      chk("R4", $sformatf("vec%0d cs length", v), r_cs, want_cs(VEC[v].mode));
      chk("R5", $sformatf("vec%0d done", v), {r_done, r_done_ok, r_gap}, {1'b1, 1'b1, 32'd0});
      chk("R6", $sformatf("vec%0d strobe/oe", v), r_oe_bad + r_wrong, 0);
      if (VEC[v].wr) begin
        chk("R6", $sformatf("vec%0d write bus", v), r_bus, VEC[v].bus);
        chk("R6", $sformatf("vec%0d bus held", v), r_bus_var, 0);
      end else begin
        chk("R7", $sformatf("vec%0d read data", v), r_rdata, VEC[v].bus);
      end
    end
    chk("R7", "rdata held over write", host_rdata_o, 16'h00C1);

    run_acc(24'h400006, 1'b0, 1'b1, 1'b0, 16'h0, 0, 0);
    chk("R2", "outside window no cs", r_cs, 0);
    chk("R2", "outside window done next cycle", {r_done, r_done_ok}, 2'b11);

    set_mode(3'd3);
    dd_i = 16'h0A0B;
    run_acc(24'hC00008, 1'b0, 1'b1, 1'b0, 16'h0, 5, 0);
    chk("R8", "mode3 wait stretch", r_pw, want_pw(3) + 5);
    chk("R8", "mode3 cs stretch", r_cs, want_cs(3) + 5);
    chk("R7", "mode3 read after wait", r_rdata, 16'h000B);

    set_mode(3'd1);
    run_acc(24'hC00008, 1'b0, 1'b1, 1'b0, 16'h0, 5, 0);
    chk("R8", "mode1 ready ignored", r_pw, want_pw(1));

    set_mode(3'd7);
    @(negedge clk);
    chk("R9", "mode above 4 rejected", mode_o, 1);

    set_mode(3'd0);
    run_acc(24'hC00002, 1'b0, 1'b1, 1'b0, 16'h0, 0, 1);
    chk("R9", "in-flight access keeps mode0", r_cs, want_cs(0));
    chk("R9", "new mode visible", mode_o, 4);
    n = 0;
    for (int i = 0; i < 6; i++) begin
      if (!cs0_n_o || !cs1_n_o || !host_rdy_o) n++;
      @(negedge clk);
    end
    chk("R5", "strobe while busy ignored", n, 0);
    run_acc(24'hC00002, 1'b0, 1'b1, 1'b0, 16'h0, 0, 0);
    chk("R9", "next access uses mode4", r_cs, want_cs(4));

    run_acc(24'hC00002, 1'b1, 1'b1, 1'b0, 16'h55AA, 0, 0);
    chk("R10", "rd+wr becomes write", r_wrong + r_oe_bad, 0);
    chk("R10", "rd+wr write data", r_bus, 16'h00AA);

    over = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule